// File: doc/BRIEF.md
# Byte SPI Controller with Debug-Halt Access Freeze

This block exchanges one byte at a time over a four-wire serial link, as either the clock-driving master or a selected slave. Software uses a small register window: a control register, a status register and one data address. Writing the data address fills the transmit holding register. Reading it returns the last byte received. Each status flag clears in two steps: the status register is read first, and then the data address is accessed.

A debug-halt input lets a debugger inspect the block without disturbing it. While the halt is active and the freeze-release bit is 0, a register access cannot change any status flag. A write to the data address is discarded and starts nothing. If a two-step clear began before the halt, it stays pending through the halt and completes after it. When the freeze-release bit is 1, accesses made during a halt behave as in normal operation.

The block also produces an output enable for each of its four pads. While the controller is enabled, these enables replace the direction settings of the shared port.

Top module: `spi_brk_top`

## Requirements
- R1: After reset, the control register (address 0) reads 0. Status (address 1) reads 1 on bit 0 (transmit-empty) and 0 on bit 1 (receive-full). Each pad enable equals the matching `portDir` bit.
- R2: In master mode (control bit 0 enable = 1, bit 1 master = 1), one exchange produces exactly eight SCK high pulses. MOSI carries the transmit byte MSB first, and the byte sampled on MISO lands in the data register (address 2).
- R3: Transmit-empty clears only on a data write that follows a status read which saw it set. That write starts the exchange. A data write that has no prior status read leaves transmit-empty set and starts nothing.
- R4: Receive-full sets when an exchange completes. A status read that sees it set, followed by a data read, clears it.
- R5: While `brkIn` is 1 and control bit 2 (freeze-release) is 0, a data write starts no exchange and transmit-empty stays 1. Reads leave every flag unchanged.
- R6: A first clear step taken before a halt keeps its flag set through the halt. The second step, taken after `brkIn` returns to 0, clears it.
- R7: With freeze-release at 1, data writes and clear sequences made during a halt act normally.
- R8: MISO is driven (`padOe[0]`) only when the controller is enabled, master is 0 and `ssInN` is low. Otherwise MISO is high-impedance.
- R9: As a slave, the block shifts the transmit byte out on MISO MSB first and captures the MOSI byte over eight SCK cycles. The SCK and select inputs are re-timed by two flops.
- R10: When the controller is enabled, the pad enables (bit 0 MISO, 1 MOSI, 2 SCK, 3 SS) come from the controller, and SCK, MOSI and SS are outputs exactly in master mode. When it is disabled, the pad enables follow `portDir`.
- R11: When a completed exchange and the second clear step of receive-full fall in the same cycle, receive-full stays set and the new byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (for side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| brkIn | input | 1 | Debug halt active |
| sckIn | input | 1 | Serial clock from a master |
| ssInN | input | 1 | Slave select, active low |
| mosiIn | input | 1 | Serial data in when slave |
| misoIn | input | 1 | Serial data in when master |
| portDir | input | 4 | Shared port direction, used when disabled |
| padOut | output | 4 | Pad values: 0 MISO, 1 MOSI, 2 SCK, 3 SS |
| padOe | output | 4 | Pad output enables, same bit order |

## Verification
The completion of an exchange and the software clear of receive-full can land on the same clock edge. The bench counts SCK rising edges at the pads until the eighth one. It then places a data read exactly one divider half-period plus one cycle later, so that the read meets the edge on which the result is captured. The outcome is judged at the register interface. That read must return the previous byte, a later status read must still show receive-full, and a proper clear sequence must then return the new byte.

// File: rtl/spi_brk_pkg.sv
package spi_brk_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int PAD_MISO = 0;
  localparam int PAD_MOSI = 1;
  localparam int PAD_SCK  = 2;
  localparam int PAD_SS   = 3;
  localparam int PAD_N    = 4;

  typedef struct packed {
    logic enable;
    logic master;
    logic loadShift;
  } spiStrobe_t;
endpackage

// File: rtl/spi_brk_ctrl.sv
module spi_brk_ctrl
  import spi_brk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    addr,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          brkIn,
  input  logic          dpBusy,
  input  logic          dpDone,
  input  logic [DW-1:0] dpRxByte,
  output spiStrobe_t    strobe,
  output logic [DW-1:0] txByte
);
  logic enBit, masterBit, relBit;
  logic txEmpty, rxFull, txArm, rxArm;
  logic [DW-1:0] txReg, rxReg;
  logic accessLive, statRd, dataRd, dataWr, loadNow;

  // accesses count only outside a frozen halt
  assign accessLive = !brkIn || relBit;
  assign statRd  = rdEn && (addr == ADDR_STAT) && accessLive;
  assign dataRd  = rdEn && (addr == ADDR_DATA) && accessLive;
  assign dataWr  = wrEn && (addr == ADDR_DATA) && accessLive;
  assign loadNow = enBit && !txEmpty && !dpBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit     <= 1'b0;
      masterBit <= 1'b0;
      relBit    <= 1'b0;
    end else if (wrEn && addr == ADDR_CTRL) begin
      enBit     <= wdata[0];
      masterBit <= wdata[1];
      relBit    <= wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg   <= '0;
      txEmpty <= 1'b1;
      txArm   <= 1'b0;
    end else begin
      if (dataWr) txReg <= wdata;
      if (statRd && txEmpty) txArm <= 1'b1;
      else if (dataWr)       txArm <= 1'b0;
      if (loadNow)                txEmpty <= 1'b1;
      else if (dataWr && txArm)   txEmpty <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg  <= '0;
      rxFull <= 1'b0;
      rxArm  <= 1'b0;
    end else begin
      if (dpDone) rxReg <= dpRxByte;
      if (statRd && rxFull) rxArm <= 1'b1;
      else if (dataRd)      rxArm <= 1'b0;
      if (dpDone)                rxFull <= 1'b1;
      else if (dataRd && rxArm)  rxFull <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CTRL: rdata[2:0] = {relBit, masterBit, enBit};
      ADDR_STAT: rdata[1:0] = {rxFull, txEmpty};
      ADDR_DATA: rdata = rxReg;
      default:   rdata = '0;
    endcase
  end

  assign strobe.enable    = enBit;
  assign strobe.master    = masterBit;
  assign strobe.loadShift = loadNow;
  assign txByte = txReg;
endmodule

// File: rtl/spi_brk_dp.sv
module spi_brk_dp
  import spi_brk_pkg::*;
#(
  parameter int DW = 8,
  parameter int HALF_DIV = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  spiStrobe_t    strobe,
  input  logic [DW-1:0] txByte,
  input  logic          sckIn,
  input  logic          ssInN,
  input  logic          mosiIn,
  input  logic          misoIn,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rxByte,
  output logic          sckOut,
  output logic          serOut,
  output logic          ssOut
);
  localparam int CNT_W = (DW > 1) ? $clog2(DW) : 1;
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic sckMeta, sckSync, sckPrev, ssMeta, ssSync;
  logic active, sckReg, inBit;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic [DW-1:0] shReg;
  logic isMaster, isSlave, tick, riseEv, fallEv, lastBit;

  assign isMaster = strobe.enable && strobe.master;
  assign isSlave  = strobe.enable && !strobe.master;
  assign tick     = isMaster && active && (divCnt == DIV_W'(HALF_DIV - 1));
  assign lastBit  = (bitCnt == CNT_W'(DW - 1));

  always_comb begin
    riseEv = 1'b0;
    fallEv = 1'b0;
    if (isMaster) begin
      riseEv = tick && !sckReg;
      fallEv = tick && sckReg;
    end else if (isSlave && !ssSync) begin
      riseEv = sckSync && !sckPrev;
      fallEv = !sckSync && sckPrev;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckMeta <= 1'b0; sckSync <= 1'b0; sckPrev <= 1'b0;
      ssMeta  <= 1'b1; ssSync  <= 1'b1;
    end else begin
      sckMeta <= sckIn;  sckSync <= sckMeta; sckPrev <= sckSync;
      ssMeta  <= ssInN;  ssSync  <= ssMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      sckReg <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
      shReg  <= '0;
      inBit  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strobe.loadShift) begin
        shReg  <= txByte;
        bitCnt <= '0;
        if (isMaster) begin
          active <= 1'b1;
          divCnt <= '0;
          sckReg <= 1'b0;
        end
      end else begin
        if (isMaster && active) begin
          divCnt <= tick ? '0 : divCnt + 1'b1;
          if (tick) sckReg <= !sckReg;
        end
        if (riseEv) inBit <= isMaster ? misoIn : mosiIn;
        if (fallEv) begin
          shReg <= {shReg[DW-2:0], inBit};
          if (lastBit) begin
            bitCnt <= '0;
            done   <= 1'b1;
            active <= 1'b0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        if (isSlave && ssSync) bitCnt <= '0;
      end
    end
  end

  assign busy   = isMaster ? active : (bitCnt != '0);
  assign rxByte = shReg;
  assign sckOut = sckReg;
  assign serOut = shReg[DW-1];
  assign ssOut  = !active;
endmodule

// File: rtl/spi_brk_top.sv
module spi_brk_top
  import spi_brk_pkg::*;
#(
  parameter int DW = 8,
  parameter int HALF_DIV = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    addr,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          brkIn,
  input  logic          sckIn,
  input  logic          ssInN,
  input  logic          mosiIn,
  input  logic          misoIn,
  input  logic [3:0]    portDir,
  output logic [3:0]    padOut,
  output logic [3:0]    padOe
);
  spiStrobe_t strobe;
  logic [DW-1:0] txByte, dpRxByte;
  logic dpBusy, dpDone, sckOut, serOut, ssOut;
  logic [PAD_N-1:0] spiOe;

  spi_brk_ctrl #(.DW(DW)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wdata(wdata), .rdata(rdata), .brkIn(brkIn), .dpBusy(dpBusy),
    .dpDone(dpDone), .dpRxByte(dpRxByte), .strobe(strobe), .txByte(txByte)
  );

  spi_brk_dp #(.DW(DW), .HALF_DIV(HALF_DIV)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txByte(txByte),
    .sckIn(sckIn), .ssInN(ssInN), .mosiIn(mosiIn), .misoIn(misoIn),
    .busy(dpBusy), .done(dpDone), .rxByte(dpRxByte),
    .sckOut(sckOut), .serOut(serOut), .ssOut(ssOut)
  );

  assign spiOe[PAD_MISO] = !strobe.master && !ssInN;
  assign spiOe[PAD_MOSI] = strobe.master;
  assign spiOe[PAD_SCK]  = strobe.master;
  assign spiOe[PAD_SS]   = strobe.master;

  assign padOut[PAD_MISO] = serOut;
  assign padOut[PAD_MOSI] = serOut;
  assign padOut[PAD_SCK]  = sckOut;
  assign padOut[PAD_SS]   = ssOut;

  genvar gi;
  generate
    for (gi = 0; gi < PAD_N; gi++) begin : gPadDir
      assign padOe[gi] = strobe.enable ? spiOe[gi] : portDir[gi];
    end
  endgenerate
endmodule

// File: rtl/spi_brk_chk.sv
module spi_brk_chk #(
  parameter int DW = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] addr,
  input logic       wrEn,
  input logic [1:0] wdata,
  input logic       ssInN,
  input logic [3:0] portDir,
  input logic [3:0] padOe,
  input logic [3:0] padOut,
  input logic       loadShift,
  input logic       dpBusy,
  input logic       dpDone
);
  logic shEn, shMaster, sckSeen;
  logic [7:0] riseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shEn <= 1'b0; shMaster <= 1'b0;
    end else if (wrEn && addr == 2'd0) begin
      shEn <= wdata[0]; shMaster <= wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseCnt <= '0; sckSeen <= 1'b0;
    end else begin
      sckSeen <= padOut[2];
      if (loadShift) riseCnt <= '0;
      else if (padOut[2] && !sckSeen && riseCnt != 8'hFF) riseCnt <= riseCnt + 1'b1;
    end
  end

  // R8
  miso_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shEn && ssInN) |-> !padOe[0]);

  // R8
  miso_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shEn && !shMaster && !ssInN) |-> padOe[0]);

  // R10
  sck_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    shEn |-> (padOe[2] == shMaster && padOe[1] == shMaster));

  // R10
  dir_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !shEn |-> (padOe == portDir));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadShift && shEn && shMaster) |=> dpBusy);

  // R2
  eight_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dpDone && shEn && shMaster) |-> (riseCnt == 8'(DW)));
endmodule

bind spi_brk_top spi_brk_chk #(.DW(DW)) uChk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wdata(wdata[1:0]),
  .ssInN(ssInN), .portDir(portDir), .padOe(padOe), .padOut(padOut),
  .loadShift(strobe.loadShift), .dpBusy(dpBusy), .dpDone(dpDone)
);

// File: tb/sim_spi_brk_top.sv
`timescale 1ns/1ps
module sim_spi_brk_top;
  localparam int HALF_DIV = 4;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;
  // {transmit byte, byte the bench returns on MISO}
  localparam logic [15:0] VEC [4] = '{16'hA53C, 16'h0180, 16'hFF00, 16'h5EE7};

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] addr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0, brkIn = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic sckIn = 1'b0, ssInN = 1'b1, mosiIn = 1'b0, misoIn = 1'b0;
  logic [3:0] portDir = 4'b1010, padOut, padOe;

  int checks = 0, errs = 0;
  int riseCount = 0, fallIdx = 0;
  logic sckPrevB = 1'b0;
  logic [7:0] mosiCap = '0, missPat = '0;

  always #10 clk = ~clk;

  spi_brk_top #(.DW(8), .HALF_DIV(HALF_DIV)) u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wdata(wdata), .rdata(rdata), .brkIn(brkIn), .sckIn(sckIn),
    .ssInN(ssInN), .mosiIn(mosiIn), .misoIn(misoIn), .portDir(portDir),
    .padOut(padOut), .padOe(padOe)
  );

  // master-side line model: counts SCK rises, captures MOSI, serves MISO
  always @(negedge clk) begin
    if (padOut[2] && !sckPrevB) begin
      riseCount++;
      mosiCap = {mosiCap[6:0], padOut[1]};
    end
    if (!padOut[2] && sckPrevB) fallIdx++;
    if (padOut[3]) fallIdx = 0;
    sckPrevB = padOut[2];
    misoIn = missPat[3'd7 - 3'(fallIdx)];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1;
    #5 d = rdata;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic mXfer(input logic [7:0] tx, input logic [7:0] pat, input string req);
    logic [7:0] d;
    missPat = pat; riseCount = 0;
    rd(A_STAT, d); wr(A_DATA, tx);
    wait (padOut[3] == 1'b0); wait (padOut[3] == 1'b1);
    repeat (4) @(negedge clk);
    chk({req, " sck pulses"}, riseCount, 8);
    chk({req, " mosi byte"}, mosiCap, tx);
  endtask

  task automatic drain(input logic [7:0] exp, input string req);
    logic [7:0] d;
    rd(A_STAT, d); chk({req, " rxFull set"}, d[1], 1'b1);
    rd(A_DATA, d); chk({req, " rx byte"}, d, exp);
    rd(A_STAT, d); chk({req, " rxFull cleared"}, d[1], 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] d, sl;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 padOe follows portDir", padOe, 4'b1010);
    rd(A_CTRL, d); chk("R1 ctrl reset", d, 8'h00);
    // R3 write without first step: no start
    wr(A_CTRL, 8'h03);
    chk("R10 master pad enables", padOe, 4'b1110);
    riseCount = 0;
    wr(A_DATA, 8'h77);
    repeat (40) @(negedge clk);
    chk("R3 unarmed write starts nothing", riseCount, 0);
    rd(A_STAT, d); chk("R1 status reset/R3 txEmpty kept", d[1:0], 2'b01);

    // R2 R3 R4 vector table
    for (int i = 0; i < 4; i++) begin
      mXfer(VEC[i][15:8], VEC[i][7:0], "R2");
      drain(VEC[i][7:0], "R4");
    end

    // R5 frozen write during halt (tx armed by last status read)
    brkIn = 1'b1; riseCount = 0;
    wr(A_DATA, 8'h3C);
    repeat (40) @(negedge clk);
    chk("R5 halt write starts nothing", riseCount, 0);
    rd(A_STAT, d); chk("R5 txEmpty stays set", d[0], 1'b1);
    brkIn = 1'b0;
    // R6 tx arm straddles the halt: write after halt completes the clear
    missPat = 8'hC5; riseCount = 0;
    wr(A_DATA, 8'h96);
    wait (padOut[3] == 1'b0); wait (padOut[3] == 1'b1);
    repeat (4) @(negedge clk);
    chk("R6 post-halt write sends byte", mosiCap, 8'h96);
    // R6 rx arm straddles the halt
    rd(A_STAT, d); chk("R6 rxFull before halt", d[1], 1'b1);
    brkIn = 1'b1;
    rd(A_DATA, d);
    rd(A_STAT, d); chk("R5 R6 rxFull held in halt", d[1], 1'b1);
    brkIn = 1'b0;
    rd(A_DATA, d); chk("R6 rx byte", d, 8'hC5);
    rd(A_STAT, d); chk("R6 cleared after halt", d[1], 1'b0);

    // R7 release bit set: halt accesses act normally
    wr(A_CTRL, 8'h07);
    brkIn = 1'b1;
    mXfer(8'h5A, 8'h69, "R7");
    drain(8'h69, "R7");
    brkIn = 1'b0;
    wr(A_CTRL, 8'h03);

    // R11 capture and clear in one cycle
    mXfer(8'h10, 8'h11, "R11");
    rd(A_STAT, d);
    missPat = 8'h33;
    wr(A_DATA, 8'h22);
    begin
      int r = 0;
      logic p = 1'b0;
      while (r < 8) begin
        @(negedge clk);
        if (padOut[2] && !p) r++;
        p = padOut[2];
      end
    end
    repeat (HALF_DIV) @(posedge clk);
    @(negedge clk); addr = A_DATA; rdEn = 1'b1;
    #5 d = rdata;
    @(negedge clk); rdEn = 1'b0;
    chk("R11 colliding read returns old byte", d, 8'h11);
    drain(8'h33, "R11");

    // R8 R9 R10 slave mode
    wr(A_CTRL, 8'h01);
    chk("R8 R10 slave deselected enables", padOe, 4'b0000);
    ssInN = 1'b0;
    @(negedge clk);
    chk("R8 slave selected drives MISO", padOe, 4'b0001);
    rd(A_STAT, d); wr(A_DATA, 8'hC3);
    repeat (8) @(negedge clk);
    sl = '0;
    for (int b = 7; b >= 0; b--) begin
      mosiIn = 8'h6B >> b;
      repeat (8) @(negedge clk);
      sl = {sl[6:0], padOut[0]};
      sckIn = 1'b1;
      repeat (8) @(negedge clk);
      sckIn = 1'b0;
    end
    repeat (8) @(negedge clk);
    chk("R9 slave MISO byte", sl, 8'hC3);
    drain(8'h6B, "R9");
    ssInN = 1'b1;
    @(negedge clk);
    chk("R8 MISO released", padOe[0], 1'b0);
    wr(A_CTRL, 8'h00);
    chk("R10 disabled follows portDir", padOe, 4'b1010);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule